// File: doc/BRIEF.md
# Cartridge Command Decoder with Checksum

This block sits between a cartridge host bus and an SD-card controller. The host hands it an 8-byte command word through a valid/ready handshake. The block stores the word and classifies it by its leading byte. It then either issues one request to the downstream controller, or reports an error pulse and issues nothing.

Each request carries a 2-bit operation code and a 32-bit address. Depending on the opcode, the address is the sector number as given, the sector number converted to a byte offset, a raw command payload, or a configuration value. One read opcode is protected by an XOR checksum in the last byte. The byte-offset opcode is refused when the attached card is marked high-capacity.

A host configuration register, written by one opcode, can be read at all times on a status port. Only one command is in flight at a time.

Top module: `cart_cmd_decoder`

## Requirements
- R1: The command word places the opcode in bits [63:56], a 32-bit sector field (most significant byte first) in bits [55:24], bytes 5 and 6 in bits [23:8] and the check byte in bits [7:0]. Request operation codes are: read = 0, write = 1, raw = 2, config = 3.
- R2: Opcode 0xB9 issues a read request (op 0) whose address equals the sector field unshifted.
- R3: Opcode 0xBB issues a write request (op 1) whose address equals the sector field unshifted.
- R4: Opcode 0xBC issues a read request (op 0) with the unshifted sector field only when bits [7:0] equal the XOR of the seven bytes above them. On a mismatch, the block raises the error pulse and issues no request.
- R5: When `card_hc` is 0, opcode 0xB4 issues a read request (op 0) whose address is the sector field shifted left by SECTOR_SHIFT (default 9), truncated to 32 bits. When `card_hc` is 1, it raises the error pulse and issues no request.
- R6: Opcode 0xC0 issues a raw request (op 2) whose address carries the 32-bit field from bits [55:24].
- R7: Opcode 0xC2 loads the low CFG_W bits of the field in bits [55:24] into `host_cfg`. It also issues a config request (op 3) whose address is that value, zero-extended.
- R8: Any other opcode raises the error pulse for one cycle, issues no request and leaves `host_cfg` unchanged.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_op` and `req_addr` hold their values. `req_valid` falls on the edge that samples `req_ready` high.
- R10: `cmd_ready` is low from the edge that accepts a command until the request handshake completes or the error pulse is given. A `cmd_valid` presented meanwhile is ignored.
- R11: The request or the error pulse appears after the second rising edge that follows acceptance. The first edge latches the command and the second evaluates it.
- R12: A synchronous active-high `rst` clears `req_valid`, `err` and `host_cfg` to zero and makes `cmd_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_data | input | 64 | Command word, opcode in the top byte |
| card_hc | input | 1 | Attached card is high-capacity |
| req_valid | output | 1 | Downstream request pending |
| req_ready | input | 1 | Downstream accepts the request |
| req_op | output | 2 | Request operation code |
| req_addr | output | 32 | Request address or payload |
| err | output | 1 | One-cycle error pulse |
| host_cfg | output | CFG_W | Host configuration register |

## Verification
The bench builds the block with its defaults: SECTOR_SHIFT of 9 and CFG_W of 8. With a shift of 9, a sector value with high bits set loses those bits when truncated to 32 bits, so the bench can check the truncation. An 8-bit configuration register lets the bench load a full byte and see it survive a rejected opcode and then clear on reset. Checksum vectors that differ from a correct one only in the check byte cover both the pass and the fail branch.

// File: rtl/cart_cmd_decoder.sv
module cart_cmd_decoder #(
  parameter int SECTOR_SHIFT = 9,
  parameter int CFG_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [63:0]      cmd_data,
  input  logic             card_hc,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [1:0]       req_op,
  output logic [31:0]      req_addr,
  output logic             err,
  output logic [CFG_W-1:0] host_cfg
);
  localparam logic [7:0] OPC_RD    = 8'hB9;
  localparam logic [7:0] OPC_WR    = 8'hBB;
  localparam logic [7:0] OPC_RDSUM = 8'hBC;
  localparam logic [7:0] OPC_RDB   = 8'hB4;
  localparam logic [7:0] OPC_RAW   = 8'hC0;
  localparam logic [7:0] OPC_CFG   = 8'hC2;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_RAW   = 2'd2;
  localparam logic [1:0] OP_CFG   = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_REQ} state_t;

  state_t      state;
  logic [63:0] cmd_q;

  wire [7:0]  opc    = cmd_q[63:56];
  wire [31:0] sector = cmd_q[55:24];
  wire [7:0]  sum    = cmd_q[63:56] ^ cmd_q[55:48] ^ cmd_q[47:40] ^ cmd_q[39:32]
                     ^ cmd_q[31:24] ^ cmd_q[23:16] ^ cmd_q[15:8];
  wire        sum_ok = (sum == cmd_q[7:0]);

  logic [31:0]      byte_addr;
  logic [CFG_W-1:0] cfg_val;
  assign byte_addr = sector << SECTOR_SHIFT;
  assign cfg_val   = sector[CFG_W-1:0];

  logic        dec_ok;
  logic        dec_cfg;
  logic [1:0]  dec_op;
  logic [31:0] dec_addr;

  always_comb begin
    dec_ok   = 1'b0;
    dec_cfg  = 1'b0;
    dec_op   = OP_READ;
    dec_addr = sector;
    case (opc)
      OPC_RD:    dec_ok = 1'b1;
      OPC_WR:    begin dec_ok = 1'b1; dec_op = OP_WRITE; end
      OPC_RDSUM: dec_ok = sum_ok;
      OPC_RDB:   begin dec_ok = !card_hc; dec_addr = byte_addr; end
      OPC_RAW:   begin dec_ok = 1'b1; dec_op = OP_RAW; end
      OPC_CFG:   begin
        dec_ok   = 1'b1;
        dec_cfg  = 1'b1;
        dec_op   = OP_CFG;
        dec_addr = 32'(cfg_val);
      end
      default:   dec_ok = 1'b0;
    endcase
  end

  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cmd_q     <= '0;
      req_valid <= 1'b0;
      req_op    <= OP_READ;
      req_addr  <= '0;
      err       <= 1'b0;
      host_cfg  <= '0;
    end else begin
      err <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          cmd_q <= cmd_data;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (dec_ok) begin
            req_valid <= 1'b1;
            req_op    <= dec_op;
            req_addr  <= dec_addr;
            if (dec_cfg) host_cfg <= cfg_val;
            state <= S_REQ;
          end else begin
            err   <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cart_cmd_decoder_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_op,
  input logic [31:0]      req_addr,
  input logic             err,
  input logic [CFG_W-1:0] host_cfg
);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr));

  // R9
  drop_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_valid);

  // R10
  busy_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !cmd_ready);

  // R10
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R4
  err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !req_valid);

  // R12
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !req_valid && !err && host_cfg == '0 && cmd_ready);
endmodule

bind cart_cmd_decoder cart_cmd_decoder_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .req_addr(req_addr), .err(err), .host_cfg(host_cfg)
);

// File: tb/cart_cmd_decoder_bench.sv
module cart_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_data = '0;
  logic        card_hc = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic        err;
  logic [7:0]  host_cfg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cart_cmd_decoder u_cart_cmd_decoder (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .card_hc(card_hc), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .err(err), .host_cfg(host_cfg)
  );

  localparam int NV = 11;
  localparam logic [63:0] V_CMD [NV] = '{
    64'hB900001020000000,  // R2
    64'hBBDEADBEEF112233,  // R3
    64'hBC123456780000B4,  // R4 good sum
    64'hBC123456780000B5,  // R4 bad sum
    64'hB400010003000000,  // R5 standard card
    64'hB400010003000000,  // R5 high capacity
    64'hC0A1B2C3D4000000,  // R6
    64'hC20000005A000000,  // R7
    64'h0012345678000000,  // R8
    64'hB4FF800001000000,  // R5 truncation
    64'hA500000011000000   // R8
  };
  localparam logic        V_HC   [NV] = '{0,0,0,0,0,1,0,0,0,0,0};
  localparam logic        V_ERR  [NV] = '{0,0,0,1,0,1,0,0,1,0,1};
  localparam logic [1:0]  V_OP   [NV] = '{0,1,0,0,0,0,2,3,0,0,0};
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h00001020, 32'hDEADBEEF, 32'h12345678, 32'h0, 32'h02000600,
    32'h0, 32'hA1B2C3D4, 32'h0000005A, 32'h0, 32'h00000200, 32'h0};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] c, input logic hc);
    @(negedge clk);
    cmd_data  = c;
    card_hc   = hc;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(cmd_ready == 1, "R12 cmd_ready", 64'(cmd_ready), 1);
    chk(req_valid == 0 && err == 0, "R12 outputs", {req_valid, err}, 0);
    chk(host_cfg == 0, "R12 host_cfg", 64'(host_cfg), 0);

    for (int i = 0; i < NV; i++) begin
      send(V_CMD[i], V_HC[i]);
      chk(cmd_ready == 0, "R10 busy after accept", 64'(cmd_ready), 0);
      chk(req_valid == 0 && err == 0, "R11 nothing on first edge",
          {req_valid, err}, 0);
      @(posedge clk); #1;
      chk(err == V_ERR[i], "R11 err timing", 64'(err), 64'(V_ERR[i]));
      chk(req_valid == !V_ERR[i], "R11 req timing", 64'(req_valid),
          64'(!V_ERR[i]));
      if (!V_ERR[i]) begin
        chk(req_op == V_OP[i], "R1 req_op", 64'(req_op), 64'(V_OP[i]));
        chk(req_addr == V_ADDR[i], "R1 req_addr", 64'(req_addr),
            64'(V_ADDR[i]));
        @(posedge clk); #1;
        chk(req_valid && req_op == V_OP[i] && req_addr == V_ADDR[i],
            "R9 held", {req_valid, req_op, req_addr}, {1'b1, V_OP[i], V_ADDR[i]});
        req_ready = 1'b1;
        @(posedge clk); #1;
        req_ready = 1'b0;
        chk(req_valid == 0 && cmd_ready == 1, "R9 released",
            {req_valid, cmd_ready}, 64'b01);
      end else begin
        @(posedge clk); #1;
        chk(err == 0 && req_valid == 0 && cmd_ready == 1, "R8 pulse ends",
            {err, req_valid, cmd_ready}, 64'b001);
      end
    end

    chk(host_cfg == 8'h5A, "R7 host_cfg kept over R8 opcode",
        64'(host_cfg), 64'h5A);

    // R10: command offered while a request is pending is ignored
    send(64'hB900000007000000, 1'b0);
    @(posedge clk); #1;
    @(negedge clk);
    cmd_data  = 64'hBB00000099000000;
    cmd_valid = 1'b1;
    repeat (2) @(posedge clk);
    #1 cmd_valid = 1'b0;
    chk(req_op == 0 && req_addr == 32'h7, "R10 busy command ignored",
        {req_op, req_addr}, {2'd0, 32'h7});
    req_ready = 1'b1;
    @(posedge clk); #1;
    req_ready = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk(req_valid == 0 && err == 0, "R10 no second request",
        {req_valid, err}, 0);

    // R12: reset clears a pending request and host_cfg
    send(64'hC200000033000000, 1'b0);
    @(posedge clk); #1;
    chk(host_cfg == 8'h33 && req_valid, "R7 second load",
        {req_valid, host_cfg}, {1'b1, 8'h33});
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk(req_valid == 0 && host_cfg == 0 && cmd_ready == 1, "R12 reset mid request",
        {req_valid, host_cfg, cmd_ready}, 64'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule